// File: doc/BRIEF.md
# Programmable priority interrupt resolver

This block works out, in the same cycle, which pending interrupt source comes first for each of two interrupt classes: fast (FIQ) and normal (IRQ). The interrupt controller core stores a table of priority slots. Each slot names one source ID and carries an enable flag. The core also holds per-source vectors of pending state, enable (unmask) state and class, and passes all of them to this block. The block returns one 32-bit word that the core presents as its "highest priority" read value.

Slot order sets the priority: slot 0 is the highest and the last slot the lowest. A slot takes part only when its flag is set and its ID names a real source. It wins its class when that source is pending, enabled and of that class. The two classes are resolved separately and packed into the two halves of the result word. The path is purely combinational, so a register read sees the answer in the cycle it is issued.

Top module: `prio_resolver`

## Requirements
- R1: A slot takes part only when bit 31 of its entry is 1 and its 6-bit ID in bits 5:0 is below NUM_SRC (40). A slot with the flag clear, or with an ID of 40 to 63, never affects the result.
- R2: Bits 30:6 of every slot entry have no effect on the result.
- R3: When no slot qualifies in either class, the result is 0x003F003F.
- R4: When an FIQ winner exists, the low half is bit 15 set plus the winner's ID in bits 5:0, with bits 14:6 zero. Otherwise the low half is 0x003F.
- R5: When an IRQ winner exists, the high half is bit 31 set plus the winner's ID in bits 21:16, with bits 30:22 zero. Otherwise the high half is 0x003F.
- R6: Within each class, the qualifying slot with the lowest index wins.
- R7: The FIQ half and the IRQ half are resolved independently. A winner in one class never changes the other half.
- R8: A slot hits only when its source is both pending and enabled. A class bit of 1 makes the hit FIQ and a class bit of 0 makes it IRQ.
- R9: When two slots name the same source ID, the lower-indexed slot decides the result.
- R10: The result follows any input change without a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| prioEntries | input | NUM_SLOTS x 32 | Priority table. Per slot: flag in bit 31, source ID in bits 5:0 |
| pendingVec | input | NUM_SRC | Raw pending state per source |
| enableVec | input | NUM_SRC | Unmask state per source |
| fiqClassVec | input | NUM_SRC | Class per source: 1 = FIQ, 0 = IRQ |
| winnerWord | output | 32 | Packed result: IRQ winner in the high half, FIQ winner in the low half |

## Verification
The bench builds the block with its default values of 40 slots and 40 sources, using a 6-bit ID field. With those values the IDs 40 to 63 are legal codes that must still be rejected, so the out-of-range filter can be exercised. All-zero and all-ones patterns reach both ends of the slot order. Random tables that often repeat IDs across slots bring the duplicate case and the mixed-class case within reach every few cycles.

// File: rtl/prio_resolver_pkg.sv
package prio_resolver_pkg;
  localparam int ENTRY_W  = 32;
  localparam int ID_W     = 6;
  localparam int FLAG_BIT = 31;
  localparam int HALF_W   = ENTRY_W / 2;

  // Result of one class after the lowest-index search
  typedef struct packed {
    logic            found;
    logic [ID_W-1:0] id;
  } winner_t;
endpackage

// File: rtl/slot_qualify.sv
// Control side: decodes every slot and raises per-slot hit strobes per class.
module slot_qualify
  import prio_resolver_pkg::*;
#(
  parameter int NUM_SLOTS = 40,
  parameter int NUM_SRC   = 40
) (
  input  logic [NUM_SLOTS-1:0][ENTRY_W-1:0] prioEntries,
  input  logic [NUM_SRC-1:0]                pendingVec,
  input  logic [NUM_SRC-1:0]                enableVec,
  input  logic [NUM_SRC-1:0]                fiqClassVec,
  output logic [NUM_SLOTS-1:0]              fiqHit,
  output logic [NUM_SLOTS-1:0]              irqHit,
  output logic [NUM_SLOTS-1:0][ID_W-1:0]    slotIds
);
  localparam int ID_SPAN = 1 << ID_W;
  localparam int PAD_W   = ID_SPAN - NUM_SRC;

  logic [ID_SPAN-1:0] activePad;
  logic [ID_SPAN-1:0] fiqPad;

  assign activePad = {{PAD_W{1'b0}}, pendingVec & enableVec};
  assign fiqPad    = {{PAD_W{1'b0}}, fiqClassVec};

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic            slotOn;
    logic            inRange;
    logic [ID_W-1:0] srcId;
    logic            srcLive;

    assign srcId    = prioEntries[s][ID_W-1:0];
    assign inRange  = ({1'b0, srcId} < (ID_W+1)'(NUM_SRC));
    assign slotOn   = prioEntries[s][FLAG_BIT] & inRange;
    assign srcLive  = activePad[srcId];
    assign slotIds[s] = srcId;
    assign fiqHit[s]  = slotOn & srcLive &  fiqPad[srcId];
    assign irqHit[s]  = slotOn & srcLive & ~fiqPad[srcId];

    always_comb begin
      // R8
      one_class_chk: assert ($onehot0({fiqHit[s], irqHit[s]}))
        else $error("slot %0d hit in both classes", s);
      // R1
      range_hit_chk: assert (!(fiqHit[s] | irqHit[s]) || (int'(slotIds[s]) < NUM_SRC))
        else $error("slot %0d hit with out-of-range id", s);
    end
  end
endmodule

// File: rtl/lowest_hit_pick.sv
// Finds the lowest-index set strobe and returns the ID that slot names.
module lowest_hit_pick
  import prio_resolver_pkg::*;
#(
  parameter int NUM_SLOTS = 40
) (
  input  logic [NUM_SLOTS-1:0]           hitVec,
  input  logic [NUM_SLOTS-1:0][ID_W-1:0] slotIds,
  output winner_t                        winner
);
  always_comb begin
    winner = '{found: 1'b0, id: '1};
    for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
      if (hitVec[s]) begin
        winner.found = 1'b1;
        winner.id    = slotIds[s];
      end
    end
  end

  always_comb begin
    // R6
    found_match_chk: assert (winner.found == (hitVec != '0))
      else $error("found flag disagrees with strobes");
    // R3
    idle_code_chk: assert (winner.found || (winner.id == '1))
      else $error("idle winner id not all ones");
  end
endmodule

// File: rtl/winner_path.sv
// Datapath: resolves both classes and packs them into the result word.
module winner_path
  import prio_resolver_pkg::*;
#(
  parameter int NUM_SLOTS = 40
) (
  input  logic [NUM_SLOTS-1:0]           fiqHit,
  input  logic [NUM_SLOTS-1:0]           irqHit,
  input  logic [NUM_SLOTS-1:0][ID_W-1:0] slotIds,
  output logic [ENTRY_W-1:0]             winnerWord
);
  localparam int GAP_W = HALF_W - 1 - ID_W;

  winner_t classWin [2];
  logic [NUM_SLOTS-1:0] classHits [2];
  logic [HALF_W-1:0] halfWord [2];

  assign classHits[0] = fiqHit;
  assign classHits[1] = irqHit;

  for (genvar c = 0; c < 2; c++) begin : g_class
    lowest_hit_pick #(.NUM_SLOTS(NUM_SLOTS)) u_pick (
      .hitVec (classHits[c]),
      .slotIds(slotIds),
      .winner (classWin[c])
    );
    assign halfWord[c] = {classWin[c].found, {GAP_W{1'b0}}, classWin[c].id};
  end

  assign winnerWord = {halfWord[1], halfWord[0]};

  always_comb begin
    // R4
    fiq_gap_chk: assert (winnerWord[HALF_W-2:ID_W] == '0)
      else $error("low half gap bits set");
    // R5
    irq_gap_chk: assert (winnerWord[ENTRY_W-2:HALF_W+ID_W] == '0)
      else $error("high half gap bits set");
    // R7
    fiq_flag_chk: assert (winnerWord[HALF_W-1] == (fiqHit != '0))
      else $error("low half flag disagrees with fiq strobes");
    // R7
    irq_flag_chk: assert (winnerWord[ENTRY_W-1] == (irqHit != '0))
      else $error("high half flag disagrees with irq strobes");
  end
endmodule

// File: rtl/prio_resolver.sv
module prio_resolver
  import prio_resolver_pkg::*;
#(
  parameter int NUM_SLOTS = 40,
  parameter int NUM_SRC   = 40
) (
  input  logic [NUM_SLOTS-1:0][ENTRY_W-1:0] prioEntries,
  input  logic [NUM_SRC-1:0]                pendingVec,
  input  logic [NUM_SRC-1:0]                enableVec,
  input  logic [NUM_SRC-1:0]                fiqClassVec,
  output logic [ENTRY_W-1:0]                winnerWord
);
  logic [NUM_SLOTS-1:0]           fiqHit;
  logic [NUM_SLOTS-1:0]           irqHit;
  logic [NUM_SLOTS-1:0][ID_W-1:0] slotIds;

  slot_qualify #(.NUM_SLOTS(NUM_SLOTS), .NUM_SRC(NUM_SRC)) u_qualify (
    .prioEntries(prioEntries),
    .pendingVec (pendingVec),
    .enableVec  (enableVec),
    .fiqClassVec(fiqClassVec),
    .fiqHit     (fiqHit),
    .irqHit     (irqHit),
    .slotIds    (slotIds)
  );

  winner_path #(.NUM_SLOTS(NUM_SLOTS)) u_path (
    .fiqHit    (fiqHit),
    .irqHit    (irqHit),
    .slotIds   (slotIds),
    .winnerWord(winnerWord)
  );
endmodule

// File: tb/tb_prio_resolver.sv
module tb_prio_resolver;
  localparam int NS = 40;
  localparam int NQ = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [NS-1:0][31:0] prioEntries;
  logic [NQ-1:0]       pendingVec, enableVec, fiqClassVec;
  logic [31:0]         winnerWord;

  int checks = 0;
  int fails  = 0;
  string tag = "R3";
  bit finished = 1'b0;

  prio_resolver #(.NUM_SLOTS(NS), .NUM_SRC(NQ)) dut (
    .prioEntries(prioEntries),
    .pendingVec (pendingVec),
    .enableVec  (enableVec),
    .fiqClassVec(fiqClassVec),
    .winnerWord (winnerWord)
  );

  // Behavioural model: scan slots from top priority, keep the first hit per class
  function automatic logic [31:0] refModel();
    int fiqId = -1;
    int irqId = -1;
    logic [15:0] lo, hi;
    for (int s = 0; s < NS; s++) begin
      int id = int'(prioEntries[s][5:0]);
      if (prioEntries[s][31] && id < NQ && pendingVec[id] && enableVec[id]) begin
        if (fiqClassVec[id] && fiqId < 0) fiqId = id;
        if (!fiqClassVec[id] && irqId < 0) irqId = id;
      end
    end
    lo = (fiqId < 0) ? 16'h003F : (16'h8000 | 16'(fiqId));
    hi = (irqId < 0) ? 16'h003F : (16'h8000 | 16'(irqId));
    return {hi, lo};
  endfunction

  task automatic checkNow(input string req);
    logic [31:0] exp = refModel();
    checks++;
    if (winnerWord !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h", req, winnerWord, exp);
    end
  endtask

  task automatic checkVal(input string req, input logic [31:0] exp);
    checks++;
    if (winnerWord !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h", req, winnerWord, exp);
    end
  endtask

  // Compare against the model on every clock, away from the driving edge
  always @(negedge clk) if (!rst && !finished) checkNow(tag);

  task automatic clearAll();
    prioEntries = '0; pendingVec = '0; enableVec = '0; fiqClassVec = '0;
  endtask

  task automatic step(); @(posedge clk); #2; endtask

  task automatic finish();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish();
  end

  initial begin
    clearAll();
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;

    // R3: nothing configured
    tag = "R3"; step(); checkVal("R3", 32'h003F003F);

    // R4: slot 5 names source 7 as FIQ
    clearAll(); tag = "R4";
    prioEntries[5] = 32'h8000_0007; pendingVec[7] = 1; enableVec[7] = 1; fiqClassVec[7] = 1;
    step(); checkVal("R4", 32'h003F8007);

    // R5: same source as IRQ
    tag = "R5"; fiqClassVec[7] = 0;
    step(); checkVal("R5", 32'h8007003F);

    // R1: out-of-range id and flag-clear slots above the real one
    tag = "R1";
    prioEntries[3] = 32'h8000_0028; prioEntries[2] = 32'h0000_0009;
    pendingVec[9] = 1; enableVec[9] = 1;
    step(); checkVal("R1", 32'h8007003F);
    prioEntries[1] = 32'h8000_003F;
    step(); checkVal("R1", 32'h8007003F);

    // R2: junk in bits 30:6
    tag = "R2"; prioEntries[5] = 32'hFFFF_FFC7;
    step(); checkVal("R2", 32'h8007003F);

    // R6: lower slot wins; swap order
    clearAll(); tag = "R6";
    prioEntries[0] = 32'h8000_000C; prioEntries[1] = 32'h8000_0014;
    pendingVec[12] = 1; enableVec[12] = 1; pendingVec[20] = 1; enableVec[20] = 1;
    step(); checkVal("R6", 32'h800C003F);
    prioEntries[0] = 32'h8000_0014; prioEntries[1] = 32'h8000_000C;
    step(); checkVal("R6", 32'h8014003F);
    prioEntries[39] = 32'h8000_0027; pendingVec[39] = 1; enableVec[39] = 1; fiqClassVec[39] = 1;
    step(); checkVal("R6", 32'h80148027);

    // R7: FIQ at high priority leaves IRQ half untouched
    tag = "R7"; prioEntries[2] = 32'h8000_0001; pendingVec[1] = 1; enableVec[1] = 1; fiqClassVec[1] = 1;
    step(); checkVal("R7", 32'h80148001);

    // R8: pending without enable, enable without pending
    clearAll(); tag = "R8";
    prioEntries[0] = 32'h8000_0004; prioEntries[1] = 32'h8000_0005;
    pendingVec[4] = 1; enableVec[5] = 1; fiqClassVec[4] = 1;
    step(); checkVal("R8", 32'h003F003F);

    // R9: two slots naming one source; lower slot decides
    clearAll(); tag = "R9";
    prioEntries[8] = 32'h8000_0003; prioEntries[4] = 32'h8000_0003; prioEntries[6] = 32'h8000_0011;
    pendingVec[3] = 1; enableVec[3] = 1; pendingVec[17] = 1; enableVec[17] = 1;
    step(); checkVal("R9", 32'h8003003F);

    // R10: mid-cycle change seen without a clock edge
    tag = "R10";
    @(negedge clk); #3;
    enableVec[3] = 0; #1;
    checkVal("R10", 32'h8011003F);
    fiqClassVec[17] = 1; #1;
    checkVal("R10", 32'h003F8011);

    // Random tables; ids drawn from a narrow set so duplicates are common
    tag = "R6";
    for (int n = 0; n < 400; n++) begin
      logic [63:0] r;
      @(posedge clk); #2;
      for (int s = 0; s < NS; s++) begin
        logic [31:0] w = $urandom();
        w[5:0] = (n % 3 == 0) ? w[5:0] : 6'(w[4:0] + 6'd10);
        w[31] = ($urandom() % 4) != 0;
        prioEntries[s] = w;
      end
      r = {$urandom(), $urandom()}; pendingVec  = r[NQ-1:0];
      r = {$urandom(), $urandom()}; enableVec   = r[NQ-1:0] | ((n % 2 == 0) ? '0 : r[NQ+7:8]);
      r = {$urandom(), $urandom()}; fiqClassVec = r[NQ-1:0];
    end

    step();
    finish();
  end
endmodule